// File: doc/BRIEF.md
# Free-Running Timer Event Flags with Read-Then-Access Clear

This block is a 16-bit free-running counter with two edge-triggered capture channels, two compare channels and a read-only status byte. Software reaches it over a simple 8-bit register bus with a 4-bit address and separate read and write strobes. Read data is combinational from the addressed register. The counter advances by one on every cycle in which the one-bit `tick` strobe is high. An external prescaler produces that strobe.

Five event flags collect in the status byte: two capture flags, two compare flags and an overflow flag. A flag is cleared only in two steps. Software first reads the status byte. It then reads or writes the low byte of the register tied to that flag. The status read records which flags were visible at that moment, and a later low-byte access clears only a recorded flag. A flag raised after the status read therefore survives. The counter can also be read at a second address pair, which never takes part in clearing overflow.

Register map (4-bit address): 0 status, 1/2 counter high/low, 3/4 alternate counter high/low, 5/6 capture 1 high/low, 7/8 capture 2 high/low, 9/10 compare 1 high/low, 11/12 compare 2 high/low, 13 control. Control bit 0 selects PWM mode. Bits 1 and 2 pick the active edge of capture inputs 0 and 1, with 1 meaning rising and 0 meaning falling. Unmapped addresses read 00h.

Top module: `tmr_flags`

## Requirements
- R1: The status byte at address 0 reads 00h after reset. Its bits are capture-1 flag at bit 7, compare-1 flag at bit 6, overflow flag at bit 5, capture-2 flag at bit 4 and compare-2 flag at bit 3. Bits 2..0 always read 0.
- R2: The counter resets to 0000h and increments by one in each cycle with `tick` high. Addresses 1/2 and 3/4 both return its high/low byte. Writes to these addresses leave the count unchanged.
- R3: The overflow flag sets on the tick that takes the counter from FFFFh to 0000h.
- R4: The overflow flag is cleared by a status read followed by a read or write of address 2. Any access to address 4 leaves it set.
- R5: Compare registers are read/write bytes at 9/10 and 11/12. They reset to 8000h and 0000h. Compare flag n sets on the tick that brings the counter to compare value n. It is cleared by a status read followed by an access to that compare register's low byte.
- R6: Each capture input passes through a two-flop synchroniser. On the edge selected by control bits 1 and 2, the count is copied into the capture register and the capture flag sets, both visible from the third clock edge after the pin change. The opposite edge does nothing. Control reads back at address 13 in bits 2..0.
- R7: With control bit 0 set, the capture-1 flag also sets on the tick that brings the counter to compare value 2. The capture-1 register keeps its value.
- R8: A low-byte access with no earlier status read showing the flag leaves that flag set.
- R9: A low-byte access clears only flags that were set at the latest status read. A flag set after that read survives.
- R10: When a flag's set event and its clearing access fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable strobe from the prescaler |
| cap_in | input | 2 | Asynchronous capture inputs, channel 1 in bit 0 |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |

## Verification
The bench touches a low byte before any status read. A design that cleared on the low-byte access alone would lose the compare flag there.

It also raises a second capture flag after the status read. A design that latched nothing at the status read would then clear both capture flags.

It touches the alternate counter low byte while overflow is pending. A design that decoded both counter views alike would drop overflow early.

It lines a PWM-mode compare hit up with a pending capture-1 clear in the same cycle. A design that let clear win would show bit 7 low.

Finally, it drives the wrong capture edge. A design that ignored the edge select would latch on both transitions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int NFLAG  = 5;
    localparam int CAP_CH = 2;
    localparam int CTRL_W = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_STAT    = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd2;
    localparam logic [ADDR_W-1:0] A_ALT_HI  = 4'd3;
    localparam logic [ADDR_W-1:0] A_ALT_LO  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAP1_HI = 4'd5;
    localparam logic [ADDR_W-1:0] A_CAP1_LO = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAP2_HI = 4'd7;
    localparam logic [ADDR_W-1:0] A_CAP2_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_CMP1_HI = 4'd9;
    localparam logic [ADDR_W-1:0] A_CMP1_LO = 4'd10;
    localparam logic [ADDR_W-1:0] A_CMP2_HI = 4'd11;
    localparam logic [ADDR_W-1:0] A_CMP2_LO = 4'd12;
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd13;

    // flag index i appears at status bit 7-i
    localparam int F_CAP1 = 0;
    localparam int F_CMP1 = 1;
    localparam int F_OVF  = 2;
    localparam int F_CAP2 = 3;
    localparam int F_CMP2 = 4;

    // control bits
    localparam int CTRL_PWM   = 0;
    localparam int CTRL_EDGE0 = 1;

    localparam logic [CNT_W-1:0] CMP1_RST = 16'h8000;
    localparam logic [CNT_W-1:0] CMP2_RST = 16'h0000;

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [CAP_CH-1:0][CNT_W-1:0] cap;
        logic [CNT_W-1:0]             cmp1;
        logic [CNT_W-1:0]             cmp2;
        logic [CTRL_W-1:0]            ctrl;
    } tmr_regs_t;
endpackage

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_i,
    output logic ev_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;
    logic              lvl;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_i};
        lvl    = sync_q[STAGES-1];
        prev_d = lvl;
        ev_o   = rise_i ? (lvl & ~prev_q) : (~lvl & prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         stat_rd_i,
    input  logic [N-1:0] acc_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] armed_o
);
    logic [N-1:0] flag_d, flag_q, armed_d, armed_q, clr;

    always_comb begin
        clr     = acc_i & armed_q;
        // set has priority over a clear in the same cycle
        flag_d  = set_i | (flag_q & ~clr);
        // a status read snapshots the visible flags; an access consumes its arm
        armed_d = stat_rd_i ? flag_q : (armed_q & ~acc_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= '0;
            armed_q <= '0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end

    assign flag_o  = flag_q;
    assign armed_o = armed_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CAP_CH-1:0] cap_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    tmr_regs_t         st_d, st_q;
    logic [CAP_CH-1:0] cap_ev;
    logic [NFLAG-1:0]  flag_set, flag_acc, flag_q, armed_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              hit1, hit2, stat_rd, acc_any;
    logic [7:0]        stat_byte;

    for (genvar g = 0; g < CAP_CH; g++) begin : g_cap
        tmr_cap_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_in[g]),
            .rise_i (st_q.ctrl[CTRL_EDGE0 + g]),
            .ev_o   (cap_ev[g])
        );
    end

    // event detection
    always_comb begin
        cnt_inc  = st_q.cnt + 1'b1;
        hit1     = tick && (cnt_inc == st_q.cmp1);
        hit2     = tick && (cnt_inc == st_q.cmp2);
        flag_set = '0;
        flag_set[F_CAP1] = cap_ev[0] | (st_q.ctrl[CTRL_PWM] & hit2);
        flag_set[F_CMP1] = hit1;
        flag_set[F_OVF]  = tick && (st_q.cnt == '1);
        flag_set[F_CAP2] = cap_ev[1];
        flag_set[F_CMP2] = hit2;

        stat_rd  = bus_rd && (bus_addr == A_STAT);
        acc_any  = bus_rd | bus_wr;
        flag_acc = '0;
        flag_acc[F_CAP1] = acc_any && (bus_addr == A_CAP1_LO);
        flag_acc[F_CMP1] = acc_any && (bus_addr == A_CMP1_LO);
        flag_acc[F_OVF]  = acc_any && (bus_addr == A_CNT_LO);
        flag_acc[F_CAP2] = acc_any && (bus_addr == A_CAP2_LO);
        flag_acc[F_CMP2] = acc_any && (bus_addr == A_CMP2_LO);
    end

    tmr_flag_ctl #(.N(NFLAG)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (flag_set),
        .stat_rd_i (stat_rd),
        .acc_i     (flag_acc),
        .flag_o    (flag_q),
        .armed_o   (armed_q)
    );

    // next-state of counter, latches and writable registers
    always_comb begin
        st_d = st_q;
        if (tick) st_d.cnt = cnt_inc;
        for (int c = 0; c < CAP_CH; c++) begin
            if (cap_ev[c]) st_d.cap[c] = st_q.cnt;
        end
        if (bus_wr) begin
            case (bus_addr)
                A_CMP1_HI: st_d.cmp1[CNT_W-1 -: 8] = bus_wdata;
                A_CMP1_LO: st_d.cmp1[7:0]          = bus_wdata;
                A_CMP2_HI: st_d.cmp2[CNT_W-1 -: 8] = bus_wdata;
                A_CMP2_LO: st_d.cmp2[7:0]          = bus_wdata;
                A_CTRL:    st_d.ctrl               = bus_wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cmp1 <= CMP1_RST;
            st_q.cmp2 <= CMP2_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        stat_byte = '0;
        for (int i = 0; i < NFLAG; i++) stat_byte[7-i] = flag_q[i];
        case (bus_addr)
            A_STAT:    bus_rdata = stat_byte;
            A_CNT_HI,
            A_ALT_HI:  bus_rdata = st_q.cnt[CNT_W-1 -: 8];
            A_CNT_LO,
            A_ALT_LO:  bus_rdata = st_q.cnt[7:0];
            A_CAP1_HI: bus_rdata = st_q.cap[0][CNT_W-1 -: 8];
            A_CAP1_LO: bus_rdata = st_q.cap[0][7:0];
            A_CAP2_HI: bus_rdata = st_q.cap[1][CNT_W-1 -: 8];
            A_CAP2_LO: bus_rdata = st_q.cap[1][7:0];
            A_CMP1_HI: bus_rdata = st_q.cmp1[CNT_W-1 -: 8];
            A_CMP1_LO: bus_rdata = st_q.cmp1[7:0];
            A_CMP2_HI: bus_rdata = st_q.cmp2[CNT_W-1 -: 8];
            A_CMP2_LO: bus_rdata = st_q.cmp2[7:0];
            A_CTRL:    bus_rdata = {{(8-CTRL_W){1'b0}}, st_q.ctrl};
            default:   bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/tmr_flags_chk.sv
module tmr_flags_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cap1,
    input logic [NFLAG-1:0]  flags,
    input logic [NFLAG-1:0]  armed,
    input logic [NFLAG-1:0]  sets,
    input logic [CAP_CH-1:0] cap_ev
);
    // R1
    stat_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[2:0] == 3'b000));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R3
    wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '1) |=> flags[F_OVF]);

    // R4
    alt_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_OVF] && (bus_rd || bus_wr) && bus_addr == A_ALT_LO) |=> flags[F_OVF]);

    // R6
    cap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev[0] |=> (cap1 == $past(cnt)));

    // R8
    unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~armed) != '0) |=>
        ((flags & $past(flags & ~armed)) == $past(flags & ~armed)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sets != '0) |=> ((flags & $past(sets)) == $past(sets)));
endmodule

bind tmr_flags tmr_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cnt       (st_q.cnt),
    .cap1      (st_q.cap[0]),
    .flags     (flag_q),
    .armed     (armed_q),
    .sets      (flag_set),
    .cap_ev    (cap_ev)
);

// File: tb/tmr_flags_tb.sv
module tmr_flags_tb;
    import tmr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [CAP_CH-1:0] cap_in = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_flags u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // reset values, register read-back (R1, R2, R5, R6)
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  8'h00, 8'h00, 4'd1},   // R1 status after reset
        '{1'b0, 4'd9,  8'h00, 8'h80, 4'd5},   // R5 compare 1 high reset
        '{1'b0, 4'd10, 8'h00, 8'h00, 4'd5},
        '{1'b0, 4'd11, 8'h00, 8'h00, 4'd5},
        '{1'b0, 4'd12, 8'h00, 8'h00, 4'd5},
        '{1'b0, 4'd1,  8'h00, 8'h00, 4'd2},   // R2 counter reset
        '{1'b0, 4'd2,  8'h00, 8'h00, 4'd2},
        '{1'b0, 4'd3,  8'h00, 8'h00, 4'd2},
        '{1'b0, 4'd4,  8'h00, 8'h00, 4'd2},
        '{1'b1, 4'd11, 8'h00, 8'h00, 4'd5},
        '{1'b1, 4'd12, 8'h10, 8'h00, 4'd5},
        '{1'b0, 4'd12, 8'h00, 8'h10, 4'd5},
        '{1'b1, 4'd9,  8'h00, 8'h00, 4'd5},
        '{1'b1, 4'd10, 8'h05, 8'h00, 4'd5},
        '{1'b0, 4'd9,  8'h00, 8'h00, 4'd5},
        '{1'b0, 4'd10, 8'h00, 8'h05, 4'd5},
        '{1'b1, 4'd13, 8'h02, 8'h00, 4'd6},   // R6 ch1 rising, ch2 falling
        '{1'b0, 4'd13, 8'h00, 8'h02, 4'd6}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_do(input logic wr, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] q;
        bus_do(1'b1, a, d, q);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] q;
        bus_do(1'b0, a, 8'h00, q);
        chk(tag, q, exp);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk);
        cap_in[ch] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd_chk(VECS[i].addr, VECS[i].exp,
                        $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // compare 1 hit at count 5; R8 access without status read
        run_ticks(5);
        wr(A_CMP1_LO, 8'h05);
        rd_chk(A_STAT, 8'h40, "R8 flag kept without status read");
        rd_chk(A_CNT_HI, 8'h00, "R2 count high");
        rd_chk(A_CNT_LO, 8'h05, "R2 count low");
        rd_chk(A_ALT_LO, 8'h05, "R2 alternate low");
        rd_chk(A_CMP1_LO, 8'h05, "R5 compare low");
        rd_chk(A_STAT, 8'h00, "R5 compare flag cleared");

        // capture 1 on rising edge
        set_pin(0, 1'b1);
        rd_chk(A_STAT, 8'h80, "R6 capture 1 flag");
        rd_chk(A_CAP1_HI, 8'h00, "R6 capture 1 high");
        rd_chk(A_CAP1_LO, 8'h05, "R6 capture 1 low");
        rd_chk(A_STAT, 8'h00, "R6 capture 1 cleared");

        // R9: flag raised after status read survives
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        rd_chk(A_STAT, 8'h80, "R6 capture 1 again");
        set_pin(1, 1'b1);
        rd_chk(A_STAT, 8'h80, "R6 rising edge ignored on falling channel");
        set_pin(1, 1'b0);
        rd_chk(A_CAP2_LO, 8'h05, "R6 capture 2 low");
        rd_chk(A_CAP1_LO, 8'h05, "R9 capture 1 low");
        rd_chk(A_STAT, 8'h10, "R9 late flag survives");
        rd_chk(A_CAP2_LO, 8'h05, "R9 capture 2 low");
        rd_chk(A_STAT, 8'h00, "R9 capture 2 cleared");

        // R7 / R10: PWM hit coincides with capture 1 clear
        wr(A_CTRL, 8'h03);
        set_pin(0, 1'b0);
        set_pin(0, 1'b1);
        run_ticks(10);
        rd_chk(A_STAT, 8'h80, "R10 armed capture 1");
        @(negedge clk);
        tick = 1'b1; bus_rd = 1'b1; bus_addr = A_CAP1_LO;
        @(posedge clk);
        #1 tick = 1'b0; bus_rd = 1'b0;
        rd_chk(A_STAT, 8'h88, "R10 set wins over clear, R7 PWM sets capture 1");
        rd_chk(A_CAP1_LO, 8'h05, "R7 capture 1 register unchanged");
        rd_chk(A_STAT, 8'h08, "R7 capture 1 cleared");
        rd_chk(A_CMP2_LO, 8'h10, "R5 compare 2 low");
        rd_chk(A_STAT, 8'h00, "R5 compare 2 cleared");
        wr(A_CTRL, 8'h02);

        // overflow, count now 0010h
        run_ticks(16'hFFEF);
        rd_chk(A_STAT, 8'h00, "R3 no overflow at FFFF");
        rd_chk(A_CNT_HI, 8'hFF, "R2 count high at FFFF");
        run_ticks(1);
        rd_chk(A_STAT, 8'h20, "R3 overflow flag");
        rd_chk(A_ALT_LO, 8'h00, "R4 alternate low after wrap");
        rd_chk(A_STAT, 8'h20, "R4 alternate access keeps overflow");
        wr(A_CNT_LO, 8'h55);
        rd_chk(A_STAT, 8'h00, "R4 overflow cleared");
        rd_chk(A_CNT_LO, 8'h00, "R2 write leaves count");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule